// File: doc/BRIEF.md
# Ping-Pong Byte DMA Channel

This block is one DMA channel that carries single bytes between memory and an attached peripheral. It can run in either direction. Software describes each buffer with a byte count and a bus address. There are two descriptor slots, and software fills them in turn. While the hardware drains one slot, software refills the other. The channel moves between the slots on its own and shows how many are loaded through a four-state occupancy code: idle, stall, on and next.

The peripheral asks for one byte at a time with a request line, and the channel answers each byte with a one-cycle acknowledge. Each byte costs one access on a simple request/acknowledge memory port. Three events can raise one level-sensitive interrupt, each with its own enable:
- a buffer finishes and the channel runs dry;
- a buffer finishes and the other loaded slot takes over;
- the memory returns an error.

Shutdown follows a fixed order. Software clears the enable, the loaded buffers drain, the channel passes through stall, and it then settles in idle.

Top module: `pp_dma_channel`

## Requirements
- R1: After reset the status state field reads 0 (idle), every register reads 0, and irq, mem_req and per_ack are low.
- R2: Writing 1 to control bit 4 while idle moves the status state (register 0x0C bits [5:4]) to 1 (stall) after the next clock edge. Writes to either slot address register while idle are ignored and read back unchanged.
- R3: In stall, writing a slot address register (slot 0 at 0x24 with count at 0x20, slot 1 at 0x34 with count at 0x30) loads that slot and gives state 2 (on). Loading the second slot gives state 3 (next). An address write to a slot that is already loaded, or whose count register holds zero, is ignored.
- R4: When port register 0x08 bit 4 is 0 (memory to peripheral), each per_req causes a memory read at the active slot's current address. The byte read is then presented on per_wdata during a one-cycle per_ack, and the address advances by one per byte.
- R5: When port register bit 4 is 1 (peripheral to memory), per_rdata is captured at the request and written to memory at the active slot's current address.
- R6: Register 0x14 reads the bytes still owed by the active slot. It reads 0 when no slot is active, and it drops by exactly one per acknowledged byte.
- R7: When the active slot empties in state next, the other slot becomes active and the state returns to on. This also sets pending flag bit 1 in register 0x04.
- R8: When the active slot empties in state on, the state becomes stall and pending flag bit 0 is set. Any accepted slot load clears flag bits 0 and 1.
- R9: irq is high exactly when some pending flag (register 0x04 bits 0, 1, 3) is set and the control enable in the same bit position is set.
- R10: A memory acknowledge with mem_err sets flag bit 3. The byte is not acknowledged to the peripheral, and neither the count nor the state changes. Writing 1 to register 0x04 bit 3 clears that flag, and writes to bits 0 and 1 of that register have no effect.
- R11: Clearing control bit 4 does not stop loaded buffers. Once they drain, the state spends one cycle in stall and then becomes idle, and it never goes straight from on or next to idle.
- R12: Port register 0x08 bits [3:0] drive per_port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte |
| mem_ack | input | 1 | Memory access complete |
| mem_err | input | 1 | Error response, valid with mem_ack |
| per_port | output | 4 | Selected peripheral |
| per_req | input | 1 | Peripheral requests one byte |
| per_ack | output | 1 | One-cycle byte acknowledge |
| per_rdata | input | 8 | Byte from peripheral |
| per_wdata | output | 8 | Byte to peripheral |
| irq | output | 1 | Level interrupt |

## Verification
Some properties hold on every cycle, and the embedded assertions check those:
- per_ack never lasts longer than one cycle;
- a pending memory request keeps its address until it is acknowledged;
- an error response is never followed by a byte acknowledge;
- state next always has both slots loaded;
- the remaining count steps down by one per byte;
- the state never leaves on or next straight for idle.

Other behaviour depends on the whole sequence, so only the bench scenarios can show it:
- the order of the slots and the alternation of the active slot;
- the byte values moved in each direction;
- which flag a slot completion raises;
- rejected descriptor writes;
- the stall-then-idle shutdown path while traffic is still running.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_STALL = 2'd1,
    CH_ON    = 2'd2,
    CH_NEXT  = 2'd3
  } ch_state_e;

  typedef enum logic [1:0] {
    MV_IDLE = 2'd0,
    MV_MEM  = 2'd1,
    MV_ACK  = 2'd2
  } mv_state_e;

  localparam int unsigned REG_AW = 8;

  localparam logic [7:0] OFS_CTRL    = 8'h00;
  localparam logic [7:0] OFS_INT     = 8'h04;
  localparam logic [7:0] OFS_PORT    = 8'h08;
  localparam logic [7:0] OFS_STAT    = 8'h0C;
  localparam logic [7:0] OFS_REM     = 8'h14;
  localparam logic [7:0] OFS_CNT0    = 8'h20;
  localparam logic [7:0] OFS_BASE0   = 8'h24;
  localparam logic [7:0] SLOT_STRIDE = 8'h10;

  // bit positions shared by the control and pending-flag registers
  localparam int unsigned BIT_STALL = 0;
  localparam int unsigned BIT_NFB   = 1;
  localparam int unsigned BIT_ERR   = 3;
  localparam int unsigned BIT_EN    = 4;

endpackage

// File: rtl/pp_dma_regs.sv
module pp_dma_regs
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic [REG_AW-1:0]             reg_addr,
  input  logic [4:0]                    wbits,
  input  ch_state_e                     state,
  input  logic                          stall_set,
  input  logic                          nfb_set,
  input  logic                          err_set,
  input  logic                          load_evt,
  input  logic [CNT_W-1:0]              remain,
  input  logic [1:0][CNT_W-1:0]         slot_cnt,
  input  logic [1:0][ADDR_W-1:0]        slot_base,
  output logic                          en,
  output logic                          dir_rx,
  output logic [3:0]                    per_port,
  output logic                          irq,
  output logic [31:0]                   reg_rdata,
  output logic [1:0]                    base_wr,
  output logic [1:0]                    cnt_wr
);

  logic en_q, en_d, ies_q, ies_d, ien_q, ien_d, iee_q, iee_d;
  logic stf_q, stf_d, nff_q, nff_d, erf_q, erf_d;
  logic [4:0] port_q, port_d;
  logic wr_ctrl, wr_int, wr_port;

  assign wr_ctrl = reg_we && (reg_addr == OFS_CTRL);
  assign wr_int  = reg_we && (reg_addr == OFS_INT);
  assign wr_port = reg_we && (reg_addr == OFS_PORT);

  for (genvar s = 0; s < 2; s++) begin : g_dec
    assign cnt_wr[s]  = reg_we && (reg_addr == 8'(OFS_CNT0  + SLOT_STRIDE * s));
    assign base_wr[s] = reg_we && (reg_addr == 8'(OFS_BASE0 + SLOT_STRIDE * s));
  end

  always_comb begin
    en_d   = en_q;
    ies_d  = ies_q;
    ien_d  = ien_q;
    iee_d  = iee_q;
    port_d = port_q;
    if (wr_ctrl) begin
      en_d  = wbits[BIT_EN];
      ies_d = wbits[BIT_STALL];
      ien_d = wbits[BIT_NFB];
      iee_d = wbits[BIT_ERR];
    end
    if (wr_port) port_d = wbits;
    stf_d = stall_set ? 1'b1 : (load_evt ? 1'b0 : stf_q);
    nff_d = nfb_set   ? 1'b1 : (load_evt ? 1'b0 : nff_q);
    erf_d = err_set   ? 1'b1 : ((wr_int && wbits[BIT_ERR]) ? 1'b0 : erf_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ies_q  <= 1'b0;
      ien_q  <= 1'b0;
      iee_q  <= 1'b0;
      stf_q  <= 1'b0;
      nff_q  <= 1'b0;
      erf_q  <= 1'b0;
      port_q <= '0;
    end else begin
      en_q   <= en_d;
      ies_q  <= ies_d;
      ien_q  <= ien_d;
      iee_q  <= iee_d;
      stf_q  <= stf_d;
      nff_q  <= nff_d;
      erf_q  <= erf_d;
      port_q <= port_d;
    end
  end

  assign en       = en_q;
  assign dir_rx   = port_q[4];
  assign per_port = port_q[3:0];
  assign irq      = (stf_q && ies_q) || (nff_q && ien_q) || (erf_q && iee_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL:  reg_rdata = {27'd0, en_q, iee_q, 1'b0, ien_q, ies_q};
      OFS_INT:   reg_rdata = {28'd0, erf_q, 1'b0, nff_q, stf_q};
      OFS_PORT:  reg_rdata = {27'd0, port_q};
      OFS_STAT:  reg_rdata = {26'd0, state, 4'd0};
      OFS_REM:   reg_rdata = 32'(remain);
      8'h20:     reg_rdata = 32'(slot_cnt[0]);
      8'h24:     reg_rdata = 32'(slot_base[0]);
      8'h30:     reg_rdata = 32'(slot_cnt[1]);
      8'h34:     reg_rdata = 32'(slot_base[1]);
      default:   reg_rdata = '0;
    endcase
  end

  // R9: with every enable clear the interrupt stays low
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ies_q && !ien_q && !iee_q) |-> !irq);

  // R10: a pending error survives until a write of 1 to its bit
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (erf_q && !wr_int) |=> erf_q);

  // R8: a slot load without a concurrent completion clears the stall flag
  p_load_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !stall_set) |=> !stf_q);

endmodule

// File: rtl/pp_dma_slots.sv
module pp_dma_slots
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [1:0]             base_wr,
  input  logic [1:0]             cnt_wr,
  input  logic [31:0]            wdata,
  input  logic                   byte_done,
  output ch_state_e              state,
  output logic                   busy,
  output logic [ADDR_W-1:0]      cur_addr,
  output logic [CNT_W-1:0]       remain,
  output logic                   stall_set,
  output logic                   nfb_set,
  output logic                   load_evt,
  output logic [1:0][CNT_W-1:0]  slot_cnt,
  output logic [1:0][ADDR_W-1:0] slot_base
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  ch_state_e               state_q, state_d;
  logic                    act_q, act_d;
  logic [1:0]              valid_q, valid_d, load_ok;
  logic [1:0][CNT_W-1:0]   rem_v;
  logic [1:0][ADDR_W-1:0]  ptr_v;
  logic                    fin;
  logic [1:0]              n_d;

  assign busy = (state_q == CH_ON) || (state_q == CH_NEXT);
  assign fin  = byte_done && (rem_v[act_q] == ONE);

  for (genvar s = 0; s < 2; s++) begin : g_slot
    logic [CNT_W-1:0]  cnt_q, rem_q;
    logic [ADDR_W-1:0] base_q, ptr_q;
    logic              v_q, is_act;

    assign is_act     = (act_q == 1'(s));
    assign load_ok[s] = base_wr[s] && !v_q && (state_q != CH_IDLE) && (cnt_q != '0);
    assign valid_d[s] = load_ok[s] ? 1'b1 : ((fin && is_act) ? 1'b0 : v_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q  <= '0;
        rem_q  <= '0;
        base_q <= '0;
        ptr_q  <= '0;
        v_q    <= 1'b0;
      end else begin
        if (cnt_wr[s]) cnt_q <= wdata[CNT_W-1:0];
        if (load_ok[s]) begin
          base_q <= wdata[ADDR_W-1:0];
          ptr_q  <= wdata[ADDR_W-1:0];
          rem_q  <= cnt_q;
        end else if (byte_done && is_act) begin
          ptr_q <= ptr_q + ADDR_W'(1);
          rem_q <= rem_q - ONE;
        end
        v_q <= valid_d[s];
      end
    end

    assign valid_q[s]   = v_q;
    assign rem_v[s]     = rem_q;
    assign ptr_v[s]     = ptr_q;
    assign slot_cnt[s]  = cnt_q;
    assign slot_base[s] = base_q;
  end

  assign n_d = 2'(valid_d[0]) + 2'(valid_d[1]);

  always_comb begin
    act_d = act_q;
    if (fin) act_d = ~act_q;
    if ((valid_q == 2'b00) && (|load_ok)) act_d = load_ok[1];
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      CH_IDLE:  state_d = en ? CH_STALL : CH_IDLE;
      CH_STALL: begin
        if (|load_ok)  state_d = CH_ON;
        else if (!en)  state_d = CH_IDLE;
      end
      default: begin
        if (n_d == 2'd2)      state_d = CH_NEXT;
        else if (n_d == 2'd1) state_d = CH_ON;
        else                  state_d = CH_STALL;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      act_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      act_q   <= act_d;
    end
  end

  assign state     = state_q;
  assign cur_addr  = ptr_v[act_q];
  assign remain    = busy ? rem_v[act_q] : '0;
  assign load_evt  = |load_ok;
  assign stall_set = (state_q == CH_ON) && fin && !(|load_ok);
  assign nfb_set   = (state_q == CH_NEXT) && fin;

  // R11: a loaded channel always passes through stall before idle
  p_no_skip_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (state_q != CH_IDLE));

  // R2: idle holds until the enable is set
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == CH_IDLE) && !en) |=> (state_q == CH_IDLE));

  // R3: state next means both slots hold a buffer
  p_next_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_NEXT) |-> (valid_q == 2'b11));

  // R6: a non-final byte lowers the remaining count by one
  p_rem_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !fin) |=> (remain == $past(remain) - ONE));

endmodule

// File: rtl/pp_dma_mover.sv
module pp_dma_mover
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              dir_rx,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              per_req,
  input  logic [7:0]        per_rdata,
  output logic              per_ack,
  output logic [7:0]        per_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              byte_done,
  output logic              err_evt
);

  mv_state_e         mv_q, mv_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        wb_q, wb_d, rb_q, rb_d;
  logic              we_q, we_d;

  always_comb begin
    mv_d   = mv_q;
    addr_d = addr_q;
    wb_d   = wb_q;
    rb_d   = rb_q;
    we_d   = we_q;
    case (mv_q)
      MV_IDLE: if (per_req && busy) begin
        mv_d   = MV_MEM;
        addr_d = cur_addr;
        wb_d   = per_rdata;
        we_d   = dir_rx;
      end
      MV_MEM: if (mem_ack) begin
        if (mem_err) mv_d = MV_IDLE;
        else begin
          mv_d = MV_ACK;
          if (!we_q) rb_d = mem_rdata;
        end
      end
      default: mv_d = MV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv_q   <= MV_IDLE;
      addr_q <= '0;
      wb_q   <= '0;
      rb_q   <= '0;
      we_q   <= 1'b0;
    end else begin
      mv_q   <= mv_d;
      addr_q <= addr_d;
      wb_q   <= wb_d;
      rb_q   <= rb_d;
      we_q   <= we_d;
    end
  end

  assign mem_req   = (mv_q == MV_MEM);
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wb_q;
  assign per_ack   = (mv_q == MV_ACK);
  assign per_wdata = rb_q;
  assign byte_done = per_ack;
  assign err_evt   = mem_req && mem_ack && mem_err;

  // R4: the byte acknowledge is a single-cycle pulse
  p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |=> !per_ack);

  // R4: an outstanding memory request keeps its address
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R10: an error response is not acknowledged to the peripheral
  p_err_no_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> !per_ack);

endmodule

// File: rtl/pp_dma_channel.sv
module pp_dma_channel
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic [3:0]        per_port,
  input  logic              per_req,
  output logic              per_ack,
  input  logic [7:0]        per_rdata,
  output logic [7:0]        per_wdata,
  output logic              irq
);

  ch_state_e              state;
  logic                   en, dir_rx, busy, byte_done, err_evt;
  logic                   stall_set, nfb_set, load_evt;
  logic [1:0]             base_wr, cnt_wr;
  logic [ADDR_W-1:0]      cur_addr;
  logic [CNT_W-1:0]       remain;
  logic [1:0][CNT_W-1:0]  slot_cnt;
  logic [1:0][ADDR_W-1:0] slot_base;

  pp_dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .wbits(reg_wdata[4:0]), .state(state), .stall_set(stall_set),
    .nfb_set(nfb_set), .err_set(err_evt), .load_evt(load_evt),
    .remain(remain), .slot_cnt(slot_cnt), .slot_base(slot_base),
    .en(en), .dir_rx(dir_rx), .per_port(per_port), .irq(irq),
    .reg_rdata(reg_rdata), .base_wr(base_wr), .cnt_wr(cnt_wr)
  );

  pp_dma_slots #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .en(en), .base_wr(base_wr), .cnt_wr(cnt_wr),
    .wdata(reg_wdata), .byte_done(byte_done), .state(state), .busy(busy),
    .cur_addr(cur_addr), .remain(remain), .stall_set(stall_set),
    .nfb_set(nfb_set), .load_evt(load_evt), .slot_cnt(slot_cnt),
    .slot_base(slot_base)
  );

  pp_dma_mover #(.ADDR_W(ADDR_W)) u_mover (
    .clk(clk), .rst_n(rst_n), .busy(busy), .dir_rx(dir_rx),
    .cur_addr(cur_addr), .per_req(per_req), .per_rdata(per_rdata),
    .per_ack(per_ack), .per_wdata(per_wdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .byte_done(byte_done), .err_evt(err_evt)
  );

endmodule

// File: tb/pp_dma_channel_tb_top.sv
`timescale 1ns/1ps
module pp_dma_channel_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;
  logic [3:0]  per_port;
  logic        per_req = 1'b0;
  logic        per_ack;
  logic [7:0]  per_rdata = '0;
  logic [7:0]  per_wdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  bit err_inject = 0;
  logic [31:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;

  always #2.5 clk = ~clk;

  pp_dma_channel dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .per_port(per_port), .per_req(per_req), .per_ack(per_ack),
    .per_rdata(per_rdata), .per_wdata(per_wdata), .irq(irq)
  );

  function automatic logic [7:0] memf(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // memory model: acknowledges one cycle after a request
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req) begin
      mem_ack   = 1'b1;
      mem_err   = err_inject;
      mem_rdata = memf(mem_addr);
      if (mem_we && !err_inject) begin
        wr_addr = mem_addr;
        wr_data = mem_wdata;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd_state(output logic [1:0] s);
    logic [31:0] v;
    rd(8'h0C, v);
    s = v[5:4];
  endtask

  task automatic xfer(input logic [7:0] din, output logic [7:0] dout, output bit seen);
    seen = 0;
    per_rdata = din;
    per_req = 1'b1;
    for (int k = 0; k < 20 && !seen; k++) begin
      @(negedge clk);
      if (per_ack) seen = 1;
    end
    dout = per_wdata;
    per_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [1:0]  s;
    logic [7:0]  got;
    bit          seen;
    bit          ack_seen;

    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_state(s);           chk("R1 state", 32'(s), 32'd0);
    rd(8'h00, v);          chk("R1 ctrl", v, 32'd0);
    rd(8'h04, v);          chk("R1 flags", v, 32'd0);
    rd(8'h14, v);          chk("R1 remain", v, 32'd0);
    chk("R1 outputs", {29'd0, irq, mem_req, per_ack}, 32'd0);

    // R12 port select
    wr(8'h08, 32'h5);
    chk("R12 per_port", 32'(per_port), 32'h5);

    // R2 address write while idle is ignored
    wr(8'h20, 32'd4);
    wr(8'h24, 32'h100);
    rd(8'h24, v);          chk("R2 idle base ignored", v, 32'd0);
    rd_state(s);           chk("R2 still idle", 32'(s), 32'd0);

    wr(8'h00, 32'h1B);
    @(negedge clk);
    rd_state(s);           chk("R2 enable to stall", 32'(s), 32'd1);

    // R3 loading
    wr(8'h24, 32'h100);
    rd_state(s);           chk("R3 stall to on", 32'(s), 32'd2);
    rd(8'h14, v);          chk("R6 remain after load", v, 32'd4);
    wr(8'h30, 32'd0);
    wr(8'h34, 32'h200);
    rd_state(s);           chk("R3 zero count ignored", 32'(s), 32'd2);
    rd(8'h34, v);          chk("R3 zero count base", v, 32'd0);
    wr(8'h30, 32'd2);
    wr(8'h34, 32'h200);
    rd_state(s);           chk("R3 on to next", 32'(s), 32'd3);
    wr(8'h24, 32'h300);
    rd(8'h24, v);          chk("R3 loaded slot ignored", v, 32'h100);

    // R4 memory to peripheral, slot 0
    for (int i = 0; i < 4; i++) begin
      xfer(8'h00, got, seen);
      chk("R4 ack seen", 32'(seen), 32'd1);
      chk("R4 byte", 32'(got), 32'(memf(32'h100 + 32'(i))));
      if (i < 3) begin
        rd(8'h14, v);      chk("R6 remain step", v, 32'(3 - i));
      end
    end
    rd_state(s);           chk("R7 next to on", 32'(s), 32'd2);
    rd(8'h14, v);          chk("R7 other slot active", v, 32'd2);
    rd(8'h04, v);          chk("R7 nfb flag", v, 32'h2);
    chk("R9 irq nfb", 32'(irq), 32'd1);

    // R10 error response
    err_inject = 1;
    ack_seen = 0;
    per_req = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (per_ack) ack_seen = 1;
    end
    per_req = 1'b0;
    repeat (3) @(negedge clk);
    err_inject = 0;
    chk("R10 no ack on error", 32'(ack_seen), 32'd0);
    rd(8'h04, v);          chk("R10 error flag", v, 32'hA);
    rd(8'h14, v);          chk("R10 count kept", v, 32'd2);
    rd_state(s);           chk("R10 state kept", 32'(s), 32'd2);
    wr(8'h04, 32'h3);
    rd(8'h04, v);          chk("R10 bits 0/1 not writable", v, 32'hA);
    wr(8'h04, 32'h8);
    rd(8'h04, v);          chk("R10 error cleared", v, 32'h2);

    // R9 disabled enable masks pending flag
    wr(8'h00, 32'h19);
    chk("R9 irq masked", 32'(irq), 32'd0);

    // slot 1 drains, R8 stall
    for (int i = 0; i < 2; i++) begin
      xfer(8'h00, got, seen);
      chk("R4 slot1 byte", 32'(got), 32'(memf(32'h200 + 32'(i))));
    end
    rd_state(s);           chk("R8 on to stall", 32'(s), 32'd1);
    rd(8'h04, v);          chk("R8 stall flag", v, 32'h3);
    chk("R9 irq stall", 32'(irq), 32'd1);
    rd(8'h14, v);          chk("R6 remain idle slot", v, 32'd0);

    // R5 peripheral to memory, R11 shutdown
    wr(8'h08, 32'h15);
    chk("R12 per_port rx", 32'(per_port), 32'h5);
    wr(8'h20, 32'd3);
    wr(8'h24, 32'h40);
    rd(8'h04, v);          chk("R8 load clears flags", v, 32'h0);
    xfer(8'hC3, got, seen);
    chk("R5 write addr", wr_addr, 32'h40);
    chk("R5 write data", 32'(wr_data), 32'hC3);
    wr(8'h00, 32'h09);
    rd_state(s);           chk("R11 keeps running", 32'(s), 32'd2);
    xfer(8'h5E, got, seen);
    chk("R5 write addr 2", wr_addr, 32'h41);
    chk("R5 write data 2", 32'(wr_data), 32'h5E);
    xfer(8'h17, got, seen);
    rd_state(s);           chk("R11 passes stall", 32'(s), 32'd1);
    @(negedge clk);
    rd_state(s);           chk("R11 reaches idle", 32'(s), 32'd0);

    // constrained random traffic
    wr(8'h00, 32'h1B);
    @(negedge clk);
    for (int it = 0; it < 30; it++) begin
      int unsigned len;
      logic [31:0] base;
      bit rx;
      logic [7:0] sl;
      len  = 1 + ($urandom % 5);
      base = $urandom & 32'hFFFF;
      rx   = 1'($urandom % 2);
      sl   = 8'((it % 2) * 16);
      wr(8'h08, {27'd0, rx, 4'h3});
      wr(8'h20 + sl, 32'(len));
      wr(8'h24 + sl, base);
      rd_state(s);         chk("R3 random load", 32'(s), 32'd2);
      for (int b = 0; b < int'(len); b++) begin
        logic [7:0] din;
        din = 8'($urandom);
        xfer(din, got, seen);
        chk("R4 random ack", 32'(seen), 32'd1);
        if (rx) begin
          chk("R5 random addr", wr_addr, base + 32'(b));
          chk("R5 random data", 32'(wr_data), 32'(din));
        end else begin
          chk("R4 random data", 32'(got), 32'(memf(base + 32'(b))));
        end
        rd(8'h14, v);      chk("R6 random remain", v, 32'(len - 32'(b) - 1));
      end
      rd_state(s);         chk("R8 random stall", 32'(s), 32'd1);
      chk("R9 random irq", 32'(irq), 32'd1);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule